// File: doc/BRIEF.md
# Common Interrupt Distributor

This block takes a set of shared, level-sensitive interrupt inputs and spreads them over the interrupt lines of a small cluster of cores. Software configures each shared interrupt through a simple command port. A command carries an opcode, an interrupt index and a data word. Through this port software sets the core mask the interrupt may reach, picks its distribution policy, and masks or unmasks it. A separate global command switches distribution on or off.

Each core receives one vector with one bit per shared interrupt. There are three policies. A fixed policy always targets one core. A broadcast policy targets every core in the mask. A rotating policy hands each new assertion to the next core in the mask and stays on that core for as long as the input stays high. Outputs are registered, so a change on an input reaches the cores one clock later.

Top module: `irq_spread_unit`

## Requirements
- R1: After reset every interrupt is masked, every core mask is zero, distribution is disabled, and `core_irq` is all zero whatever `irq_in` does.
- R2: Opcode 3 sets global distribution on when `cmd_data[0]` is 1 and off when it is 0. While distribution is off, `core_irq` is zero.
- R3: Opcode 0 writes `cmd_data[NUM_CORE-1:0]` as the core mask of interrupt `cmd_idx`, with bit c standing for core c. No core outside the mask is ever driven, and a zero mask drives no core.
- R4: Opcode 1 takes the policy from `cmd_data[1:0]`. Every other data bit, including the trigger-type bit 4 and bits [3:2], has no effect.
- R5: Opcode 2 masks interrupt `cmd_idx` when `cmd_data[0]` is 1 and unmasks it when it is 0. A masked interrupt drives no core.
- R6: Policy 0 (fixed) and policy 3 (reserved) deliver only to the lowest-numbered core in the mask.
- R7: Policy 2 (broadcast) delivers to every core in the mask at once.
- R8: Under policy 1 (rotating), each new assertion goes to the next core in the mask above the one served last, wrapping to the lowest. The first assertion after reset goes to the lowest core in the mask.
- R9: Under policy 1, the chosen core stays the same for as long as the input stays high. The rotation moves on only after the input falls.
- R10: Inputs are level-sensitive. An output bit falls one cycle after its input falls.
- R11: Interrupt i for core c appears on `core_irq[c*NUM_IRQ+i]`, one clock after the input and configuration that cause it. A configuration command takes effect on the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 2 | 0 core mask, 1 policy, 2 mask bit, 3 global enable |
| cmd_idx | input | $clog2(NUM_IRQ) | Shared interrupt addressed by the command |
| cmd_data | input | DATA_W | Command data word |
| irq_in | input | NUM_IRQ | Shared level interrupt inputs |
| core_irq | output | NUM_CORE*NUM_IRQ | Per-core interrupt vectors, core-major |

## Verification
Some properties are checked by assertions on every cycle. An ineligible or deasserted interrupt never reaches a core. No core outside the mask is ever driven. The fixed and rotating policies never drive more than one core. A rotating target holds while its input stays high. Each command also lands in its configuration field. The bench scenarios cover what a single-cycle property cannot show. Those are the wrap-around order of the rotation over several assertions, the lowest-core choice after reset, the one-edge delay before a command takes effect, the ignored bits of the policy word, and the mapping of several interrupts onto the core-major output.

// File: rtl/isu_pkg.sv
package isu_pkg;

    typedef enum logic [1:0] {
        OP_DEST   = 2'd0,
        OP_POLICY = 2'd1,
        OP_MASK   = 2'd2,
        OP_GLOBAL = 2'd3
    } isu_op_e;

    typedef enum logic [1:0] {
        POL_FIXED  = 2'd0,
        POL_ROTATE = 2'd1,
        POL_ALL    = 2'd2,
        POL_RSVD   = 2'd3
    } isu_pol_e;

endpackage

// File: rtl/isu_cfg_bank.sv
module isu_cfg_bank #(
    parameter int NUM_IRQ  = 8,
    parameter int NUM_CORE = 4,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cmd_valid,
    input  logic [1:0]                         cmd_op,
    input  logic [IDX_W-1:0]                   cmd_idx,
    input  logic [DATA_W-1:0]                  cmd_data,
    output logic [NUM_IRQ-1:0][NUM_CORE-1:0]   dest_o,
    output logic [NUM_IRQ-1:0][1:0]            pol_o,
    output logic [NUM_IRQ-1:0]                 mask_o,
    output logic                               en_o
);
    import isu_pkg::*;

    typedef struct packed {
        logic [NUM_IRQ-1:0][NUM_CORE-1:0] dest;
        logic [NUM_IRQ-1:0][1:0]          pol;
        logic [NUM_IRQ-1:0]               mask;
        logic                             en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic idx_ok;
    logic unused_data_bits;

    assign unused_data_bits = ^cmd_data;
    assign idx_ok = (int'(cmd_idx) < NUM_IRQ);

    always_comb begin
        cfg_d = cfg_q;
        if (cmd_valid) begin
            case (isu_op_e'(cmd_op))
                OP_DEST:   if (idx_ok) cfg_d.dest[cmd_idx] = cmd_data[NUM_CORE-1:0];
                OP_POLICY: if (idx_ok) cfg_d.pol[cmd_idx]  = cmd_data[1:0];
                OP_MASK:   if (idx_ok) cfg_d.mask[cmd_idx] = cmd_data[0];
                default:   cfg_d.en = cmd_data[0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.dest <= '0;
            cfg_q.pol  <= '0;
            cfg_q.mask <= '1;
            cfg_q.en   <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign dest_o = cfg_q.dest;
    assign pol_o  = cfg_q.pol;
    assign mask_o = cfg_q.mask;
    assign en_o   = cfg_q.en;

    // R2
    global_en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd3) |=> (en_o == $past(cmd_data[0])));

    // R5
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd2 && idx_ok) |=> (mask_o[$past(cmd_idx)] == $past(cmd_data[0])));

    // R3
    dest_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd0 && idx_ok) |=> (dest_o[$past(cmd_idx)] == $past(cmd_data[NUM_CORE-1:0])));

endmodule

// File: rtl/isu_route_lane.sv
module isu_route_lane #(
    parameter int NUM_CORE = 4,
    parameter int CIDX_W   = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic                mask_i,
    input  logic [NUM_CORE-1:0] dest_i,
    input  logic [1:0]          pol_i,
    input  logic                irq_i,
    output logic [NUM_CORE-1:0] out_o
);
    import isu_pkg::*;

    typedef struct packed {
        logic                held;
        logic [CIDX_W-1:0]   cur;
        logic [CIDX_W-1:0]   last;
        logic [NUM_CORE-1:0] out;
    } lane_t;

    lane_t ln_d, ln_q;
    logic              elig;
    logic              start;
    logic              found;
    logic [CIDX_W-1:0] pick;
    logic [CIDX_W-1:0] low;

    assign elig  = en_i && !mask_i && (|dest_i);
    assign start = irq_i && elig && !ln_q.held;

    // next core in the mask above the last one served, wrapping
    always_comb begin
        pick  = ln_q.cur;
        found = 1'b0;
        for (int k = 1; k <= NUM_CORE; k++) begin
            if (!found && dest_i[(int'(ln_q.last) + k) % NUM_CORE]) begin
                pick  = CIDX_W'((int'(ln_q.last) + k) % NUM_CORE);
                found = 1'b1;
            end
        end
    end

    // lowest core in the mask
    always_comb begin
        low = '0;
        for (int k = NUM_CORE - 1; k >= 0; k--) begin
            if (dest_i[k]) low = CIDX_W'(k);
        end
    end

    always_comb begin
        ln_d = ln_q;
        ln_d.held = irq_i && (ln_q.held || start);
        if (start) ln_d.cur = pick;
        if (ln_q.held && !irq_i) ln_d.last = ln_q.cur;

        if (!irq_i || !elig) begin
            ln_d.out = '0;
        end else begin
            case (isu_pol_e'(pol_i))
                POL_ALL:    ln_d.out = dest_i;
                POL_ROTATE: ln_d.out = ln_q.held
                                ? ((NUM_CORE'(1) << ln_q.cur) & dest_i)
                                : (NUM_CORE'(1) << pick);
                default:    ln_d.out = NUM_CORE'(1) << low;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_q.held <= 1'b0;
            ln_q.cur  <= '0;
            ln_q.last <= CIDX_W'(NUM_CORE - 1);
            ln_q.out  <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign out_o = ln_q.out;

    // R1 R2 R5
    blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i || mask_i) |=> (out_o == '0));

    // R3
    outside_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((out_o & ~$past(dest_i)) == '0));

    // R10
    level_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_i |=> (out_o == '0));

    // R6
    fixed_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_i && elig && (pol_i == 2'd0 || pol_i == 2'd3)) |=> ($countones(out_o) == 1));

    // R8
    rotate_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_i == 2'd1) |=> ($countones(out_o) <= 1));

    // R9
    rotate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_i == 2'd1 && $stable(pol_i) && irq_i && elig && $countones(out_o) == 1
         && (out_o & dest_i) != '0) |=> (out_o == $past(out_o)));

endmodule

// File: rtl/irq_spread_unit.sv
module irq_spread_unit #(
    parameter int NUM_IRQ  = 8,
    parameter int NUM_CORE = 4,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
    localparam int OUT_W   = NUM_CORE * NUM_IRQ
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [NUM_IRQ-1:0] irq_in,
    output logic [OUT_W-1:0]  core_irq
);
    logic [NUM_IRQ-1:0][NUM_CORE-1:0] dest_w;
    logic [NUM_IRQ-1:0][1:0]          pol_w;
    logic [NUM_IRQ-1:0]               mask_w;
    logic                             en_w;
    logic [NUM_IRQ-1:0][NUM_CORE-1:0] lane_out;

    isu_cfg_bank #(
        .NUM_IRQ  (NUM_IRQ),
        .NUM_CORE (NUM_CORE),
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_idx   (cmd_idx),
        .cmd_data  (cmd_data),
        .dest_o    (dest_w),
        .pol_o     (pol_w),
        .mask_o    (mask_w),
        .en_o      (en_w)
    );

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_lane
        isu_route_lane #(
            .NUM_CORE (NUM_CORE)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (en_w),
            .mask_i (mask_w[i]),
            .dest_i (dest_w[i]),
            .pol_i  (pol_w[i]),
            .irq_i  (irq_in[i]),
            .out_o  (lane_out[i])
        );
        for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
            assign core_irq[c*NUM_IRQ + i] = lane_out[i][c];
        end
    end

    // R2
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_w |=> (core_irq == '0));

endmodule

// File: tb/sim_irq_spread_unit.sv
module sim_irq_spread_unit;

    localparam int NI = 8;
    localparam int NC = 4;

    typedef struct packed {
        logic        cv;
        logic [1:0]  op;
        logic [2:0]  idx;
        logic [7:0]  data;
        logic [7:0]  irq;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t TAB [NV] = '{
        '{1'b1, 2'd0, 3'd0, 8'h06, 8'h01, 32'h0000_0000, 8'd2},  // R2 dest, still off
        '{1'b1, 2'd2, 3'd0, 8'h00, 8'h01, 32'h0000_0000, 8'd2},  // R2 unmask, still off
        '{1'b1, 2'd3, 3'd0, 8'h01, 8'h01, 32'h0000_0000, 8'd2},  // R2 enable lands at edge
        '{1'b0, 2'd0, 3'd0, 8'h00, 8'h01, 32'h0000_0100, 8'd6},  // R6 fixed -> core1
        '{1'b0, 2'd0, 3'd0, 8'h00, 8'h00, 32'h0000_0000, 8'd10}, // R10 drop
        '{1'b1, 2'd1, 3'd0, 8'h21, 8'h00, 32'h0000_0000, 8'd4},  // R4 rotate, bit5 ignored
        '{1'b0, 2'd0, 3'd0, 8'h00, 8'h01, 32'h0001_0000, 8'd8},  // R8 next -> core2
        '{1'b0, 2'd0, 3'd0, 8'h00, 8'h01, 32'h0001_0000, 8'd9},  // R9 held
        '{1'b0, 2'd0, 3'd0, 8'h00, 8'h00, 32'h0000_0000, 8'd10}, // R10
        '{1'b0, 2'd0, 3'd0, 8'h00, 8'h01, 32'h0000_0100, 8'd8},  // R8 wrap -> core1
        '{1'b0, 2'd0, 3'd0, 8'h00, 8'h00, 32'h0000_0000, 8'd10}, // R10
        '{1'b1, 2'd1, 3'd0, 8'h0E, 8'h00, 32'h0000_0000, 8'd4},  // R4 bits3:2 ignored -> all
        '{1'b0, 2'd0, 3'd0, 8'h00, 8'h01, 32'h0001_0100, 8'd7},  // R7 cores1,2
        '{1'b1, 2'd2, 3'd0, 8'h01, 8'h01, 32'h0001_0100, 8'd11}, // R11 mask lands at edge
        '{1'b0, 2'd0, 3'd0, 8'h00, 8'h01, 32'h0000_0000, 8'd5},  // R5 masked
        '{1'b1, 2'd2, 3'd0, 8'h00, 8'h01, 32'h0000_0000, 8'd5},  // R5
        '{1'b0, 2'd0, 3'd0, 8'h00, 8'h01, 32'h0001_0100, 8'd5},  // R5 unmasked
        '{1'b1, 2'd0, 3'd0, 8'h00, 8'h01, 32'h0001_0100, 8'd3},  // R3 zero dest issued
        '{1'b0, 2'd0, 3'd0, 8'h00, 8'h01, 32'h0000_0000, 8'd3},  // R3 zero dest quiet
        '{1'b1, 2'd0, 3'd0, 8'h09, 8'h01, 32'h0000_0000, 8'd3},  // R3
        '{1'b0, 2'd0, 3'd0, 8'h00, 8'h01, 32'h0100_0001, 8'd3},  // R3 cores0,3
        '{1'b0, 2'd0, 3'd0, 8'h00, 8'h00, 32'h0000_0000, 8'd10}, // R10
        '{1'b1, 2'd0, 3'd1, 8'h08, 8'h00, 32'h0000_0000, 8'd3},  // R3
        '{1'b1, 2'd2, 3'd1, 8'h00, 8'h00, 32'h0000_0000, 8'd5},  // R5
        '{1'b0, 2'd0, 3'd0, 8'h00, 8'h03, 32'h0300_0001, 8'd11}, // R11 two lines
        '{1'b1, 2'd1, 3'd1, 8'h03, 8'h03, 32'h0300_0001, 8'd6},  // R6 reserved
        '{1'b1, 2'd0, 3'd1, 8'h0C, 8'h03, 32'h0300_0001, 8'd11}, // R11
        '{1'b0, 2'd0, 3'd0, 8'h00, 8'h03, 32'h0102_0001, 8'd6},  // R6 lowest -> core2
        '{1'b1, 2'd3, 3'd0, 8'h00, 8'h03, 32'h0102_0001, 8'd2},  // R2 disable issued
        '{1'b0, 2'd0, 3'd0, 8'h00, 8'h03, 32'h0000_0000, 8'd2}   // R2 off
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [2:0]  cmd_idx = '0;
    logic [31:0] cmd_data = '0;
    logic [7:0]  irq_in = '0;
    logic [31:0] core_irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int cycles = 0;

    irq_spread_unit #(.NUM_IRQ(NI), .NUM_CORE(NC), .DATA_W(32)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_idx   (cmd_idx),
        .cmd_data  (cmd_data),
        .irq_in    (irq_in),
        .core_irq  (core_irq)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: got %0d cycles exp completion", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input logic [31:0] exp, input int req);
        checks++;
        if (core_irq !== exp) begin
            fails++;
            $display("FAIL R%0d: got %h exp %h", req, core_irq, exp);
        end
    endtask

    task automatic apply(input logic cv, input logic [1:0] op, input logic [2:0] idx,
                         input logic [7:0] data, input logic [7:0] irq,
                         input logic [31:0] exp, input int req);
        cmd_valid = cv;
        cmd_op    = op;
        cmd_idx   = idx;
        cmd_data  = {24'h0, data};
        irq_in    = irq;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        check(exp, req);
    endtask

    initial begin
        irq_in = 8'hFF;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(32'h0, 1);  // R1 reset state, inputs high

        for (int n = 0; n < NV; n++) begin
            apply(TAB[n].cv, TAB[n].op, TAB[n].idx, TAB[n].data, TAB[n].irq,
                  TAB[n].exp, int'(TAB[n].req));
        end

        // mid-run reset: defaults come back (R1)
        irq_in = 8'h00;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        check(32'h0, 1);
        apply(1'b1, 2'd3, 3'd0, 8'h01, 8'hFF, 32'h0, 1);      // R1 enable issued
        apply(1'b0, 2'd0, 3'd0, 8'h00, 8'hFF, 32'h0, 1);      // R1 all masked
        apply(1'b1, 2'd2, 3'd0, 8'h00, 8'hFF, 32'h0, 1);      // R1 unmask irq0
        apply(1'b0, 2'd0, 3'd0, 8'h00, 8'hFF, 32'h0, 1);      // R1 zero dest default
        apply(1'b1, 2'd0, 3'd0, 8'h06, 8'h00, 32'h0, 3);      // R3
        apply(1'b1, 2'd1, 3'd0, 8'h01, 8'h00, 32'h0, 4);      // R4
        apply(1'b0, 2'd0, 3'd0, 8'h00, 8'h01, 32'h0000_0100, 8);  // R8 first -> lowest
        apply(1'b0, 2'd0, 3'd0, 8'h00, 8'h03, 32'h0000_0100, 9);  // R9 irq1 masked, hold

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule